// File: doc/BRIEF.md
# Ring Arc Corner Candidate Detector

This block decides, one pixel per clock, whether a pixel is a corner candidate. The pixel is taken together with the sixteen pixels that lie on a radius-3 discrete ring around it inside a 7×7 window, plus an intensity threshold. Each ring pixel is sorted into one of three classes: brighter than the centre by more than the threshold, darker than the centre by more than the threshold, or neither.

The pixel is a candidate when enough neighbouring ring positions share the same class. The block looks for ARC_LEN consecutive positions (nine by default) that are all bright or all dark. The run may wrap past the last ring position back to the first. Every start position is tested at once, with no early rejection step.

The two class masks come out after one register stage, so a later scoring stage can use them. The candidate flag comes out after a second register stage. Window extraction, scoring and suppression are outside this block.

Top module: `seg_corner_test`

## Requirements
- R1: Ring pixel p is bright when p > center + thresh. The sum is taken without wrapping, so when center + thresh ≥ 255 no pixel is bright. A pixel equal to center + thresh is not bright.
- R2: Ring pixel p is dark when p < center − thresh. The difference is taken without wrapping, so when center < thresh no pixel is dark. A pixel equal to center − thresh is not dark.
- R3: Ring pixel k sits in bits [k*8 +: 8] of ring_px. Index 0 is the pixel at offset (0,−3), and the index increases clockwise. Bit k of bright_mask and of dark_mask is the class of pixel k. Both masks are registered one cycle after an accepted input (in_valid high), and mask_valid is in_valid delayed by one cycle.
- R4: While in_valid is low, bright_mask and dark_mask keep their previous values whatever the data inputs do.
- R5: One cycle after mask_valid, out_valid rises. corner_flag is 1 exactly when bright_mask or dark_mask holds ARC_LEN (default 9) circularly consecutive ones.
- R6: A run that crosses from index 15 back to index 0 counts the same as any other run.
- R7: corner_flag is 0 whenever out_valid is 0.
- R8: A run of ARC_LEN−1 positions does not make a candidate. A bright run and a dark run that sit side by side are not joined.
- R9: After reset, all masks, valids and the flag are 0.
- R10: A new input is accepted on every cycle. Back-to-back pixels each give their own result, with a fixed latency of two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel is present this cycle |
| center | input | PIX_W | Centre pixel intensity |
| thresh | input | PIX_W | Intensity threshold |
| ring_px | input | RING_N*PIX_W | Ring pixels, index 0 at the bottom slice |
| mask_valid | output | 1 | Masks hold a new result |
| bright_mask | output | RING_N | Per-position bright class |
| dark_mask | output | RING_N | Per-position dark class |
| out_valid | output | 1 | corner_flag holds a new result |
| corner_flag | output | 1 | Corner candidate decision |

## Verification
When pixels stream back to back, two things happen in the same clock. The masks of the newer pixel are registered while the run decision for the older pixel is registered. The bench provokes this with unbroken runs of pixels of mixed class and random arc placement, so a newer pixel's masks must never leak into the older pixel's flag. A behavioural model moves its own expected masks and flag through two delay steps. It is compared with every output on every clock, which catches any leakage between the stages or any slip in latency.

// File: rtl/corner_seg_pkg.sv
package corner_seg_pkg;
   // Fixed ring size of a radius-3 discrete circle
   localparam int unsigned RING_SIZE   = 16;
   localparam int unsigned DEF_PIX_W   = 8;
   localparam int unsigned DEF_ARC_LEN = 9;

   typedef enum logic [1:0] {
      PX_NONE   = 2'd0,
      PX_BRIGHT = 2'd1,
      PX_DARK   = 2'd2
   } px_class_e;
endpackage

// File: rtl/seg_pixel_cmp.sv
module seg_pixel_cmp
   import corner_seg_pkg::*;
#(
   parameter int unsigned PIX_W = DEF_PIX_W
) (
   input  logic [PIX_W-1:0] pix,
   input  logic [PIX_W-1:0] center,
   input  logic [PIX_W-1:0] thresh,
   output px_class_e        cls
);
   localparam int unsigned EXT_W = PIX_W + 1;

   logic [EXT_W-1:0] upper;
   logic [EXT_W-1:0] pix_plus_t;
   logic             is_bright;
   logic             is_dark;

   // Widened sums: neither bound wraps
   assign upper      = {1'b0, center} + {1'b0, thresh};
   assign pix_plus_t = {1'b0, pix} + {1'b0, thresh};
   assign is_bright  = {1'b0, pix} > upper;
   assign is_dark    = pix_plus_t < {1'b0, center};

   always_comb begin
      if (is_bright)    cls = PX_BRIGHT;
      else if (is_dark) cls = PX_DARK;
      else              cls = PX_NONE;
   end
endmodule

// File: rtl/seg_ring_classify.sv
module seg_ring_classify
   import corner_seg_pkg::*;
#(
   parameter int unsigned PIX_W  = DEF_PIX_W,
   parameter int unsigned RING_N = RING_SIZE
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [PIX_W-1:0]        center,
   input  logic [PIX_W-1:0]        thresh,
   input  logic [RING_N*PIX_W-1:0] ring_px,
   output logic                    mask_valid,
   output logic [RING_N-1:0]       bright_mask,
   output logic [RING_N-1:0]       dark_mask
);
   px_class_e         cls [RING_N];
   logic [RING_N-1:0] nxt_bright;
   logic [RING_N-1:0] nxt_dark;

   for (genvar k = 0; k < RING_N; k++) begin : g_pos
      seg_pixel_cmp #(.PIX_W(PIX_W)) u_cmp (
         .pix    (ring_px[k*PIX_W +: PIX_W]),
         .center (center),
         .thresh (thresh),
         .cls    (cls[k])
      );
      assign nxt_bright[k] = (cls[k] == PX_BRIGHT);
      assign nxt_dark[k]   = (cls[k] == PX_DARK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_valid  <= 1'b0;
         bright_mask <= '0;
         dark_mask   <= '0;
      end else begin
         mask_valid <= in_valid;
         if (in_valid) begin
            bright_mask <= nxt_bright;
            dark_mask   <= nxt_dark;
         end
      end
   end
endmodule

// File: rtl/seg_arc_scan.sv
module seg_arc_scan
   import corner_seg_pkg::*;
#(
   parameter int unsigned RING_N  = RING_SIZE,
   parameter int unsigned ARC_LEN = DEF_ARC_LEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [RING_N-1:0] bright,
   input  logic [RING_N-1:0] dark,
   output logic              valid_o,
   output logic              flag_o
);
   localparam int unsigned DBL_W = 2 * RING_N;

   logic [DBL_W-1:0]  dbl_bright;
   logic [DBL_W-1:0]  dbl_dark;
   logic [RING_N-1:0] hit_bright;
   logic [RING_N-1:0] hit_dark;
   logic              any_hit;

   // Doubling the ring lets every wrapped arc be a plain slice
   assign dbl_bright = {bright, bright};
   assign dbl_dark   = {dark, dark};

   for (genvar s = 0; s < RING_N; s++) begin : g_start
      assign hit_bright[s] = &dbl_bright[s +: ARC_LEN];
      assign hit_dark[s]   = &dbl_dark[s +: ARC_LEN];
   end

   assign any_hit = (|hit_bright) | (|hit_dark);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         flag_o  <= 1'b0;
      end else begin
         valid_o <= valid_i;
         flag_o  <= valid_i & any_hit;
      end
   end
endmodule

// File: rtl/seg_corner_test.sv
module seg_corner_test
   import corner_seg_pkg::*;
#(
   parameter int unsigned PIX_W   = DEF_PIX_W,
   parameter int unsigned RING_N  = RING_SIZE,
   parameter int unsigned ARC_LEN = DEF_ARC_LEN
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [PIX_W-1:0]        center,
   input  logic [PIX_W-1:0]        thresh,
   input  logic [RING_N*PIX_W-1:0] ring_px,
   output logic                    mask_valid,
   output logic [RING_N-1:0]       bright_mask,
   output logic [RING_N-1:0]       dark_mask,
   output logic                    out_valid,
   output logic                    corner_flag
);
   if (PIX_W < 1) begin : g_bad_pix
      $error("seg_corner_test: PIX_W must be at least 1");
   end
   if (RING_N < 2) begin : g_bad_ring
      $error("seg_corner_test: RING_N must be at least 2");
   end
   if (ARC_LEN < 1 || ARC_LEN > RING_N) begin : g_bad_arc
      $error("seg_corner_test: ARC_LEN must lie in 1..RING_N");
   end

   seg_ring_classify #(.PIX_W(PIX_W), .RING_N(RING_N)) u_classify (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .center      (center),
      .thresh      (thresh),
      .ring_px     (ring_px),
      .mask_valid  (mask_valid),
      .bright_mask (bright_mask),
      .dark_mask   (dark_mask)
   );

   seg_arc_scan #(.RING_N(RING_N), .ARC_LEN(ARC_LEN)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (mask_valid),
      .bright  (bright_mask),
      .dark    (dark_mask),
      .valid_o (out_valid),
      .flag_o  (corner_flag)
   );
endmodule

// File: rtl/seg_corner_test_chk.sv
module seg_corner_test_chk #(
   parameter int unsigned RING_N  = 16,
   parameter int unsigned ARC_LEN = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              mask_valid,
   input logic [RING_N-1:0] bright_mask,
   input logic [RING_N-1:0] dark_mask,
   input logic              out_valid,
   input logic              corner_flag
);
   AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (bright_mask & dark_mask) == '0);                                   // R1
   AST_MVALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> mask_valid);                                           // R3
   AST_MVALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !mask_valid);                                         // R3
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(bright_mask) && $stable(dark_mask)));        // R4
   AST_OVALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      mask_valid |=> out_valid);                                          // R5
   AST_FLAG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      corner_flag |-> (($countones($past(bright_mask)) >= ARC_LEN) ||
                       ($countones($past(dark_mask)) >= ARC_LEN)));       // R5
   AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !corner_flag);                                       // R7
endmodule

bind seg_corner_test seg_corner_test_chk #(.RING_N(RING_N), .ARC_LEN(ARC_LEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .mask_valid  (mask_valid),
   .bright_mask (bright_mask),
   .dark_mask   (dark_mask),
   .out_valid   (out_valid),
   .corner_flag (corner_flag)
);

// File: tb/seg_corner_test_bench.sv
module seg_corner_test_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PIX_W      = 8;
   localparam int RING_N     = 16;
   localparam int ARC_LEN    = 9;
   localparam int WATCHDOG   = 100000;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic [PIX_W-1:0]        center = '0;
   logic [PIX_W-1:0]        thresh = '0;
   logic [RING_N*PIX_W-1:0] ring_px = '0;
   logic                    mask_valid;
   logic [RING_N-1:0]       bright_mask;
   logic [RING_N-1:0]       dark_mask;
   logic                    out_valid;
   logic                    corner_flag;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   bit    cmp_on = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R9";

   // Behavioural reference state
   logic [RING_N-1:0] m_b = '0, m_d = '0;
   logic              m_mv = 1'b0, m_ov = 1'b0, m_flag = 1'b0;

   seg_corner_test #(.PIX_W(PIX_W), .RING_N(RING_N), .ARC_LEN(ARC_LEN)) u_seg_corner_test (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .center(center), .thresh(thresh),
      .ring_px(ring_px), .mask_valid(mask_valid), .bright_mask(bright_mask),
      .dark_mask(dark_mask), .out_valid(out_valid), .corner_flag(corner_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [RING_N-1:0] ref_mask(input logic [RING_N*PIX_W-1:0] r,
                                                 input int c, input int t, input bit want_bright);
      logic [RING_N-1:0] m;
      for (int k = 0; k < RING_N; k++) begin
         int p;
         p = int'(r[k*PIX_W +: PIX_W]);
         m[k] = want_bright ? (p > c + t) : (p < c - t);
      end
      return m;
   endfunction

   function automatic bit has_run(input logic [RING_N-1:0] m);
      int run, best;
      run = 0; best = 0;
      for (int i = 0; i < 2*RING_N; i++) begin
         if (m[i % RING_N]) run++; else run = 0;
         if (run > best) best = run;
      end
      return best >= ARC_LEN;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_b <= '0; m_d <= '0; m_mv <= 1'b0; m_ov <= 1'b0; m_flag <= 1'b0;
      end else begin
         if (in_valid) begin
            m_b <= ref_mask(ring_px, int'(center), int'(thresh), 1'b1);
            m_d <= ref_mask(ring_px, int'(center), int'(thresh), 1'b0);
         end
         m_mv   <= in_valid;
         m_ov   <= m_mv;
         m_flag <= m_mv && (has_run(m_b) || has_run(m_d));
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk("bright_mask", int'(bright_mask), int'(m_b));
         chk("dark_mask",   int'(dark_mask),   int'(m_d));
         chk("mask_valid",  int'(mask_valid),  int'(m_mv));
         chk("out_valid",   int'(out_valid),   int'(m_ov));
         chk("corner_flag", int'(corner_flag), int'(m_flag));
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic fill_all(input int v);
      for (int k = 0; k < RING_N; k++) ring_px[k*PIX_W +: PIX_W] = PIX_W'(v);
   endtask

   task automatic send(input int c, input int t);
      center = PIX_W'(c); thresh = PIX_W'(t); in_valid = 1'b1;
      @(negedge clk);
   endtask

   // kind 1 bright, 2 dark; rest of ring equals centre
   task automatic send_arc(input int start, input int len, input int kind);
      fill_all(128);
      for (int j = 0; j < len; j++)
         ring_px[((start + j) % RING_N)*PIX_W +: PIX_W] = (kind == 1) ? 8'd149 : 8'd107;
      send(128, 20);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cur_req = "R9";
      repeat (3) @(negedge clk);
      chk("reset flag", int'(corner_flag), 0);
      chk("reset masks", int'(bright_mask | dark_mask), 0);
      cmp_on = 1'b1;
      rst_n = 1'b1;
      idle(2);

      // Bit ordering: one bright pixel at each index
      cur_req = "R3";
      for (int k = 0; k < RING_N; k++) begin
         fill_all(128);
         ring_px[k*PIX_W +: PIX_W] = 8'd200;
         send(128, 20);
      end
      idle(2);

      // Every start position, both classes; wrapped starts go to R6
      for (int s = 0; s < RING_N; s++) begin
         for (int kind = 1; kind <= 2; kind++) begin
            cur_req = (s + ARC_LEN > RING_N) ? "R6" : "R5";
            send_arc(s, ARC_LEN, kind);
         end
      end
      idle(2);

      // One short of a run; bright and dark halves side by side
      cur_req = "R8";
      for (int s = 0; s < RING_N; s += 3) send_arc(s, ARC_LEN - 1, 1);
      fill_all(128);
      for (int k = 0; k < 8; k++) ring_px[k*PIX_W +: PIX_W] = 8'd200;
      for (int k = 8; k < 16; k++) ring_px[k*PIX_W +: PIX_W] = 8'd50;
      send(128, 20);
      idle(2);

      // Bright boundaries and no wrap of centre + thresh
      cur_req = "R1";
      fill_all(255); send(250, 10);
      fill_all(255); send(255, 0);
      fill_all(120); send(100, 20);
      fill_all(121); send(100, 20);
      idle(2);

      // Dark boundaries and no wrap of centre - thresh
      cur_req = "R2";
      fill_all(0);  send(5, 10);
      fill_all(80); send(100, 20);
      fill_all(79); send(100, 20);
      idle(2);

      // Masks hold while inputs idle with changing data
      cur_req = "R4";
      send_arc(4, 10, 2);
      in_valid = 1'b0;
      for (int i = 0; i < 6; i++) begin
         center = PIX_W'($urandom_range(0, 255));
         thresh = PIX_W'($urandom_range(0, 30));
         fill_all(int'($urandom_range(0, 255)));
         @(negedge clk);
      end
      cur_req = "R7";
      idle(3);

      // Back-to-back stream of mixed pixels
      cur_req = "R10";
      for (int n = 0; n < 400; n++) begin
         int c, t, st, ln, kind;
         c = int'($urandom_range(40, 215)); t = int'($urandom_range(0, 35));
         st = int'($urandom_range(0, 15)); ln = int'($urandom_range(6, 12));
         kind = int'($urandom_range(1, 2));
         for (int k = 0; k < RING_N; k++)
            ring_px[k*PIX_W +: PIX_W] = PIX_W'($urandom_range(0, 255));
         for (int j = 0; j < ln; j++)
            ring_px[((st + j) % RING_N)*PIX_W +: PIX_W] =
               (kind == 1) ? PIX_W'(c + t + 1) : PIX_W'(c - t - 1);
         send(c, t);
      end
      idle(4);
      finish_run();
   end
endmodule